// File: doc/BRIEF.md
# Top pending interrupt selector

This block belongs to one interrupt file of an external interrupt controller that is tightly coupled to a single hart. It keeps a pending bit for each of up to 63 interrupt identities. Enable bits, 8-bit priorities, source modes and conditioned source signals come in from neighbouring logic. In every cycle it finds the most urgent identity that is both pending and enabled, and it masks that result with a programmable threshold. It shows the outcome as a packed top-interrupt word and drives the hart's external interrupt request.

Software claims the reported interrupt by writing the top-interrupt CSR. The claim clears the pending bit only for sources whose mode holds the pending state in this block. Sources in level mode copy their conditioned input, so a claim does not affect them. Software can also write single pending bits by identity. The source mode decides whether such a write has any effect.

Top module: `irq_top_select`

## Requirements
- R1: While reset is asserted and right after it, every pending bit is clear, `top_word` is zero and `irq_req` is low.
- R2: `top_word` bits 26:16 hold the reported identity and bits 10:0 hold its priority, zero-extended. All other bits are zero. The whole word is zero when no identity qualifies.
- R3: The reported identity is the pending and enabled identity with the numerically smallest priority. Equal priorities go to the lower identity number. An identity whose enable bit is low is never reported, but it keeps its pending bit.
- R4: With `thresh` nonzero, an identity qualifies only if its priority is strictly below `thresh`. With `thresh` zero there is no masking.
- R5: `irq_req` is high exactly when `deliv_en` is high and some identity qualifies. `top_word` does not depend on `deliv_en`.
- R6: A pulse on `claim_wr` clears the reported identity's pending bit on the next clock edge if that source is in mode 1 (detached) or mode 2 (edge). If nothing is reported, the claim has no effect.
- R7: In mode 3 (level), the pending bit copies `src_level` one cycle later. Claims and software writes do not change it.
- R8: In mode 2 (edge), a `src_rise` pulse sets the pending bit. A software write with value 1 also sets it, and a software write with value 0 clears it.
- R9: In mode 1 (detached), only a software write with value 1 sets the pending bit, and `src_rise` is ignored.
- R10: In mode 0 (off), the pending bit stays clear. Software writes and `src_rise` are ignored.
- R11: When a set event (`src_rise` in edge mode, or a software write of 1) falls in the same cycle as a claim of that identity, the pending bit ends up set.
- R12: Identity 0 and identities above `NUM_ID` are never pending. Writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_mode | input | 64x2 | Per-identity source mode: 0 off, 1 detached, 2 edge, 3 level |
| src_level | input | 64 | Conditioned level per identity (level mode) |
| src_rise | input | 64 | Conditioned rising-edge pulse per identity (edge mode) |
| id_en | input | 64 | Per-identity enable |
| id_prio | input | 64xPRIO_W | Per-identity priority number |
| thresh | input | PRIO_W | Priority threshold, 0 means no masking |
| deliv_en | input | 1 | Delivery enable for `irq_req` |
| sw_wr | input | 1 | Software pending-bit write strobe |
| sw_id | input | 6 | Identity addressed by the software write |
| sw_val | input | 1 | Value written to the pending bit |
| claim_wr | input | 1 | Claim strobe (write to the top-interrupt CSR) |
| top_word | output | 32 | Packed identity and priority of the top interrupt |
| irq_req | output | 1 | External interrupt request to the hart |

## Verification
Two events can land on the same identity in the same cycle: a claim, and a new set event for that identity. The bench arranges this on an edge-mode source by asserting `src_rise` and `claim_wr` together while that identity is the one being reported. After the edge, `top_word` must still report it, because a set takes priority over a claim. A second collision is also checked: a claim made while the threshold hides every candidate must leave the pending state untouched, and the bench confirms this once the mask is lifted.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  localparam int MAX_LANES = 64;
  localparam int LANE_W    = 6;
  localparam int ID_LSB    = 16;

  typedef enum logic [1:0] {
    SM_OFF    = 2'd0,
    SM_DETACH = 2'd1,
    SM_EDGE   = 2'd2,
    SM_LEVEL  = 2'd3
  } src_mode_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irqsel_pkg::*;
#(
  parameter int NUM_ID = 63
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MAX_LANES-1:0][1:0]     src_mode,
  input  logic [MAX_LANES-1:0]          src_level,
  input  logic [MAX_LANES-1:0]          src_rise,
  input  logic                          sw_wr,
  input  logic [LANE_W-1:0]             sw_id,
  input  logic                          sw_val,
  input  logic                          clm_fire,
  input  logic [LANE_W-1:0]             clm_id,
  output logic [MAX_LANES-1:0]          pend_q
);
  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    if (i == 0 || i > NUM_ID) begin : g_absent
      logic unused_lane;
      assign unused_lane = ^{src_mode[i], src_level[i], src_rise[i]};
      assign pend_q[i]   = 1'b0;
    end else begin : g_live
      logic hit_sw, do_set, do_clr, nxt, ce, q;

      always_comb begin
        hit_sw = sw_wr && (sw_id == LANE_W'(i));
        do_set = 1'b0;
        do_clr = 1'b0;
        nxt    = q;
        unique case (src_mode[i])
          SM_OFF: nxt = 1'b0;
          SM_LEVEL: nxt = src_level[i];
          SM_DETACH: begin
            do_set = hit_sw && sw_val;
            do_clr = (hit_sw && !sw_val) || (clm_fire && clm_id == LANE_W'(i));
            nxt    = do_set ? 1'b1 : (do_clr ? 1'b0 : q);
          end
          default: begin
            do_set = src_rise[i] || (hit_sw && sw_val);
            do_clr = (hit_sw && !sw_val) || (clm_fire && clm_id == LANE_W'(i));
            nxt    = do_set ? 1'b1 : (do_clr ? 1'b0 : q);
          end
        endcase
        ce = (nxt != q);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= 1'b0;
        else if (ce) q <= nxt;
      end

      assign pend_q[i] = q;
    end
  end
endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irqsel_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic [MAX_LANES-1:0]             req,
  input  logic [MAX_LANES-1:0][PRIO_W-1:0] prio,
  output logic                             win_vld,
  output logic [LANE_W-1:0]                win_id,
  output logic [PRIO_W-1:0]                win_prio
);
  localparam int NODES = 2 * MAX_LANES;

  logic              nv [1:NODES-1];
  logic [LANE_W-1:0] nid[1:NODES-1];
  logic [PRIO_W-1:0] np [1:NODES-1];

  for (genvar n = MAX_LANES; n < NODES; n++) begin : g_leaf
    assign nv[n]  = req[n-MAX_LANES];
    assign nid[n] = LANE_W'(n - MAX_LANES);
    assign np[n]  = prio[n-MAX_LANES];
  end

  for (genvar n = 1; n < MAX_LANES; n++) begin : g_node
    logic take_l;
    assign take_l = nv[2*n] && (!nv[2*n+1] || (np[2*n] <= np[2*n+1]));
    assign nv[n]  = nv[2*n] || nv[2*n+1];
    assign nid[n] = take_l ? nid[2*n] : nid[2*n+1];
    assign np[n]  = take_l ? np[2*n]  : np[2*n+1];
  end

  assign win_vld  = nv[1];
  assign win_id   = nid[1];
  assign win_prio = np[1];
endmodule

// File: rtl/irq_top_select.sv
module irq_top_select
  import irqsel_pkg::*;
#(
  parameter int NUM_ID = 63,
  parameter int PRIO_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [MAX_LANES-1:0][1:0]        src_mode,
  input  logic [MAX_LANES-1:0]             src_level,
  input  logic [MAX_LANES-1:0]             src_rise,
  input  logic [MAX_LANES-1:0]             id_en,
  input  logic [MAX_LANES-1:0][PRIO_W-1:0] id_prio,
  input  logic [PRIO_W-1:0]                thresh,
  input  logic                             deliv_en,
  input  logic                             sw_wr,
  input  logic [LANE_W-1:0]                sw_id,
  input  logic                             sw_val,
  input  logic                             claim_wr,
  output logic [31:0]                      top_word,
  output logic                             irq_req
);
  localparam int ID_FIELD_W = 11;
  localparam int PR_FIELD_W = 11;

  logic [MAX_LANES-1:0] pend_q;
  logic [MAX_LANES-1:0] live;
  logic                 win_vld, qual, clm_fire;
  logic [LANE_W-1:0]    win_id;
  logic [PRIO_W-1:0]    win_prio;

  irq_pend_bank #(.NUM_ID(NUM_ID)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_mode (src_mode),
    .src_level(src_level),
    .src_rise (src_rise),
    .sw_wr    (sw_wr),
    .sw_id    (sw_id),
    .sw_val   (sw_val),
    .clm_fire (clm_fire),
    .clm_id   (win_id),
    .pend_q   (pend_q)
  );

  assign live = pend_q & id_en;

  irq_prio_tree #(.PRIO_W(PRIO_W)) u_tree (
    .req     (live),
    .prio    (id_prio),
    .win_vld (win_vld),
    .win_id  (win_id),
    .win_prio(win_prio)
  );

  always_comb begin
    qual     = win_vld && ((thresh == '0) || (win_prio < thresh));
    clm_fire = claim_wr && qual;
    top_word = '0;
    if (qual) begin
      top_word[ID_LSB +: ID_FIELD_W] = ID_FIELD_W'(win_id);
      top_word[0 +: PR_FIELD_W]      = PR_FIELD_W'(win_prio);
    end
    irq_req = qual && deliv_en;
  end
endmodule

// File: rtl/irq_top_select_chk.sv
module irq_top_select_chk
  import irqsel_pkg::*;
#(
  parameter int NUM_ID = 63,
  parameter int PRIO_W = 8
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [MAX_LANES-1:0][1:0]        src_mode,
  input logic [MAX_LANES-1:0]             src_level,
  input logic [MAX_LANES-1:0]             src_rise,
  input logic [MAX_LANES-1:0]             id_en,
  input logic [MAX_LANES-1:0][PRIO_W-1:0] id_prio,
  input logic [PRIO_W-1:0]                thresh,
  input logic                             deliv_en,
  input logic                             sw_wr,
  input logic [LANE_W-1:0]                sw_id,
  input logic                             sw_val,
  input logic                             claim_wr,
  input logic [31:0]                      top_word,
  input logic                             irq_req,
  input logic [MAX_LANES-1:0]             pend
);
  logic              shown;
  logic [LANE_W-1:0] tid;
  assign shown = (top_word != 32'd0);
  assign tid   = top_word[ID_LSB +: LANE_W];

  p_prio_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shown |-> top_word[10:0] == 11'(id_prio[tid]));

  p_winner_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shown |-> (pend[tid] && id_en[tid]));

  p_thresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shown && thresh != '0) |-> top_word[PRIO_W-1:0] < thresh);

  p_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (deliv_en && shown));

  p_claim_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_wr && shown &&
     (src_mode[tid] == SM_DETACH || src_mode[tid] == SM_EDGE) &&
     !src_rise[tid] && !(sw_wr && sw_id == tid && sw_val))
    |=> !pend[$past(tid)]);

  for (genvar i = 1; i <= NUM_ID; i++) begin : g_lane
    p_level_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[i] == SM_LEVEL) |=> pend[i] == $past(src_level[i]));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (src_mode[i] == SM_EDGE && src_rise[i]) |=> pend[i]);
  end
endmodule

bind irq_top_select irq_top_select_chk #(.NUM_ID(NUM_ID), .PRIO_W(PRIO_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .src_mode (src_mode),
  .src_level(src_level),
  .src_rise (src_rise),
  .id_en    (id_en),
  .id_prio  (id_prio),
  .thresh   (thresh),
  .deliv_en (deliv_en),
  .sw_wr    (sw_wr),
  .sw_id    (sw_id),
  .sw_val   (sw_val),
  .claim_wr (claim_wr),
  .top_word (top_word),
  .irq_req  (irq_req),
  .pend     (pend_q)
);

// File: tb/irq_top_select_test.sv
module irq_top_select_test;
  localparam int CLK_PERIOD = 10;
  localparam int N_ID = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [63:0][1:0]  mode;
  logic [63:0]       lvl, rise, en;
  logic [63:0][7:0]  pr;
  logic [7:0]        thr;
  logic              dlv, swr, swv, clm;
  logic [5:0]        swid;
  logic [31:0]       top_word;
  logic              irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_top_select #(.NUM_ID(N_ID), .PRIO_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .src_mode(mode), .src_level(lvl), .src_rise(rise),
    .id_en(en), .id_prio(pr), .thresh(thr), .deliv_en(dlv), .sw_wr(swr),
    .sw_id(swid), .sw_val(swv), .claim_wr(clm), .top_word(top_word), .irq_req(irq_req)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sw_write(input int id, input logic v);
    swid = 6'(id); swv = v; swr = 1'b1;
    tick();
    swr = 1'b0;
  endtask

  task automatic claim();
    clm = 1'b1;
    tick();
    clm = 1'b0;
  endtask

  function automatic logic [31:0] word(input int id, input int p);
    return (32'(id) << 16) | 32'(p);
  endfunction

  function automatic logic [31:0] calc_top(input logic [63:0] p);
    int best = -1;
    for (int i = 1; i <= N_ID; i++)
      if (p[i] && en[i] && (best < 0 || pr[i] < pr[best])) best = i;
    if (best < 0) return 32'd0;
    if (thr != 8'd0 && !(pr[best] < thr)) return 32'd0;
    return word(best, int'(pr[best]));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] model;
    logic [31:0] e;
    rst_n = 1'b0;
    mode = '0; lvl = '0; rise = '0; en = '0; pr = '0;
    thr = '0; dlv = 1'b0; swr = 1'b0; swv = 1'b0; clm = 1'b0; swid = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset word", top_word, 32'd0);
    chk("R1 reset irq", 32'(irq_req), 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", top_word, 32'd0);

    // all detached, enabled, priorities with ties
    for (int i = 0; i < 64; i++) begin
      mode[i] = 2'd1;
      en[i]   = 1'b1;
      pr[i]   = 8'(((i * 5) % 7) * 16);
    end
    dlv = 1'b1;
    for (int i = 0; i < 64; i++) sw_write(i, 1'b1);
    chk("R2 packing id7 prio0", top_word, 32'h0007_0000);
    model = '0;
    for (int i = 1; i <= N_ID; i++) model[i] = 1'b1;
    for (int k = 0; k <= N_ID; k++) begin
      e = calc_top(model);
      chk("R3 ordered claim sweep", top_word, e);
      chk("R5 irq with pending", 32'(irq_req), 32'(e != 0));
      claim();
      if (e != 0) model[e[21:16]] = 1'b0;
    end
    chk("R6 all claimed", top_word, 32'd0);
    sw_write(20, 1'b1);
    sw_write(0, 1'b1);
    sw_write(63, 1'b1);
    chk("R12 absent ids ignored", top_word, 32'd0);

    // threshold sweep on id5 (prio 64)
    sw_write(5, 1'b1);
    chk("R2 packing id5 prio64", top_word, 32'h0005_0040);
    for (int t = 0; t < 256; t++) begin
      thr = 8'(t);
      #1;
      e = (t == 0 || 64 < t) ? word(5, 64) : 32'd0;
      chk("R4 threshold sweep", top_word, e);
    end
    thr = 8'd0;
    #1;
    dlv = 1'b0;
    #1;
    chk("R5 delivery off irq", 32'(irq_req), 32'd0);
    chk("R5 delivery off word", top_word, word(5, 64));
    dlv = 1'b1;
    #1;
    chk("R5 delivery on irq", 32'(irq_req), 32'd1);
    claim();
    chk("R6 detached claim", top_word, 32'd0);

    // edge mode on id3 (prio 16)
    mode[3] = 2'd2;
    rise[3] = 1'b1; tick(); rise[3] = 1'b0;
    chk("R8 rise sets", top_word, word(3, 16));
    claim();
    chk("R6 edge claim", top_word, 32'd0);
    rise[3] = 1'b1; tick(); rise[3] = 1'b0;
    rise[3] = 1'b1; clm = 1'b1; tick(); rise[3] = 1'b0; clm = 1'b0;
    chk("R11 rise beats claim", top_word, word(3, 16));
    sw_write(3, 1'b0);
    chk("R8 sw clear", top_word, 32'd0);
    sw_write(3, 1'b1);
    chk("R8 sw set", top_word, word(3, 16));
    swid = 6'd3; swv = 1'b1; swr = 1'b1; clm = 1'b1; tick(); swr = 1'b0; clm = 1'b0;
    chk("R11 sw set beats claim", top_word, word(3, 16));
    sw_write(3, 1'b0);

    // detached ignores rise
    rise[4] = 1'b1; tick(); rise[4] = 1'b0;
    chk("R9 detached ignores rise", top_word, 32'd0);

    // level mode on id6 (prio 32)
    mode[6] = 2'd3;
    lvl[6] = 1'b1; tick();
    chk("R7 level high", top_word, word(6, 32));
    claim();
    chk("R7 claim no effect", top_word, word(6, 32));
    sw_write(6, 1'b0);
    chk("R7 sw clear no effect", top_word, word(6, 32));
    lvl[6] = 1'b0; tick();
    chk("R7 level low", top_word, 32'd0);
    sw_write(6, 1'b1);
    chk("R7 sw set no effect", top_word, 32'd0);

    // off mode on id7
    mode[7] = 2'd0;
    sw_write(7, 1'b1);
    rise[7] = 1'b1; tick(); rise[7] = 1'b0;
    chk("R10 off mode ignored", top_word, 32'd0);

    // enable masking on id8 (prio 80)
    en[8] = 1'b0;
    sw_write(8, 1'b1);
    chk("R3 disabled not reported", top_word, 32'd0);
    en[8] = 1'b1;
    #1;
    chk("R3 pending kept while disabled", top_word, word(8, 80));
    sw_write(8, 1'b0);

    // claim with nothing reported: id9 (prio 48) masked by threshold
    sw_write(9, 1'b1);
    thr = 8'd10;
    #1;
    chk("R4 masked", top_word, 32'd0);
    claim();
    thr = 8'd0;
    #1;
    chk("R6 empty claim no effect", top_word, word(9, 48));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule